// File: doc/BRIEF.md
# Bitfield Deposit Unit

This block writes a right-justified bit field into a 32-bit word. The caller gives the field length, the bit position where the lowest field bit must land, the source data and the old destination word. Each operation has mode flags. The first flag selects between merging the field into the old destination and clearing every bit outside the field. The second flag selects between a full register operand and a small signed immediate as the field data. The third flag selects between the immediate position and a stored position value.

The stored position lives in a small register with its own write port. Software can set it once and reuse it across many operations. The result is registered and appears with a valid strobe one cycle after the operation is presented.

Two combinations are useful shortcuts. Zero mode with a register source and full length gives a logical left shift. Immediate mode with an all-ones or all-zero immediate sets or clears an arbitrary field.

Top module: `fld_insert_unit`

## Requirements
- R1: For a length L and position P, result bits [P+L-1:P] equal bits [L-1:0] of the selected field data.
- R2: When `op_zero_fill` is 1, every result bit outside the field is 0.
- R3: When `op_zero_fill` is 0, every result bit outside the field equals the same bit of `op_old_dst`.
- R4: When `op_use_var_pos` is 1, the position is taken from the stored position register and `op_pos` is ignored.
- R5: The stored position register is 5 bits wide and resets to 0. A write with `pos_wr_en`=1 takes effect from the next cycle. An operation presented in the same cycle as a write uses the previous value.
- R6: When `op_use_imm` is 1, the field data is `op_imm` read as a 5-bit two's-complement value (range -16 to +15) and sign-extended to 32 bits. `op_src` is then ignored.
- R7: Field bits that would land above bit 31 are discarded, and bit 31 is the top of the field mask.
- R8: A length of 0 gives `op_old_dst` unchanged in merge mode and 0 in zero mode. A length above 32 acts as 32.
- R9: `res_valid` is 1 in exactly the cycle after a cycle with `op_valid`=1. `res_data` changes only in that cycle and otherwise holds its value.
- R10: After reset, `res_valid` is 0, `res_data` is 0 and the stored position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos_wr_en | input | 1 | Write strobe for the stored position register |
| pos_wr_data | input | 5 | New stored position value |
| op_valid | input | 1 | Operation present this cycle |
| op_use_var_pos | input | 1 | 1: use the stored position; 0: use `op_pos` |
| op_use_imm | input | 1 | 1: field data is sign-extended `op_imm`; 0: `op_src` |
| op_zero_fill | input | 1 | 1: clear bits outside the field; 0: keep `op_old_dst` bits |
| op_pos | input | 5 | Immediate LSB position of the field |
| op_len | input | 6 | Field length in bits (0..63; values above 32 act as 32) |
| op_src | input | 32 | Register field data, right-justified |
| op_imm | input | 5 | Signed immediate field data |
| op_old_dst | input | 32 | Old destination word used for merging |
| res_valid | output | 1 | Result valid strobe |
| res_data | output | 32 | Registered deposit result |

## Verification
On every cycle, the assertions check the valid latency, the hold of `res_data` between operations, and the update of the stored position on a write. On every result, they also check that the bits outside the field are cleared in zero mode, or copied from the old destination in merge mode. The bench scenarios are needed to show where the field lands and how it is clipped at the top of the word. They also cover sign extension of the immediate, the choice between the immediate position and the stored position, the same-cycle write ordering, and the length-zero and over-length cases. The bench checks these against a bit-by-bit model.

// File: rtl/fld_pkg.sv
package fld_pkg;
  localparam int unsigned FLD_WORD_W = 32;
  localparam int unsigned FLD_IMM_W  = 5;

  typedef struct packed {
    logic use_var_pos;
    logic use_imm;
    logic zero_fill;
  } fld_mode_t;
endpackage

// File: rtl/fld_pos_reg.sv
module fld_pos_reg #(
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] pos_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else if (wr_en) pos_q <= wr_data;
  end

  // R5: a write is visible in the following cycle
  p_pos_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pos_q == $past(wr_data));
  // R5: without a write the stored position holds
  p_pos_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pos_q));
endmodule

// File: rtl/fld_operand_sel.sv
module fld_operand_sel #(
  parameter int unsigned W  = 32,
  parameter int unsigned PW = 5,
  parameter int unsigned IW = 5
) (
  input  logic          use_imm,
  input  logic          use_var_pos,
  input  logic [W-1:0]  src,
  input  logic [IW-1:0] imm,
  input  logic [PW-1:0] imm_pos,
  input  logic [PW-1:0] reg_pos,
  output logic [W-1:0]  field_data,
  output logic [PW-1:0] eff_pos
);
  localparam int unsigned EXT_W = W - IW;

  function automatic logic [W-1:0] sext_imm(input logic [IW-1:0] v);
    return {{EXT_W{v[IW-1]}}, v};
  endfunction

  always_comb begin
    field_data = use_imm ? sext_imm(imm) : src;
    eff_pos    = use_var_pos ? reg_pos : imm_pos;
  end
endmodule

// File: rtl/fld_place.sv
module fld_place #(
  parameter int unsigned W  = 32,
  parameter int unsigned PW = 5,
  parameter int unsigned LW = 6
) (
  input  logic [PW-1:0] pos,
  input  logic [LW-1:0] len,
  input  logic [W-1:0]  data,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  placed
);
  // ones in the low n bits; n >= W yields all ones
  function automatic logic [W-1:0] low_ones(input logic [LW-1:0] n);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++)
      if (i < int'(n)) r[i] = 1'b1;
    return r;
  endfunction

  logic [W-1:0] len_mask;

  always_comb begin
    len_mask = low_ones(len);
    mask     = len_mask << pos;
    placed   = (data & len_mask) << pos;
  end
endmodule

// File: rtl/fld_insert_unit.sv
module fld_insert_unit
  import fld_pkg::*;
#(
  parameter int unsigned W  = FLD_WORD_W,
  parameter int unsigned IW = FLD_IMM_W,
  parameter int unsigned PW = $clog2(W),
  parameter int unsigned LW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pos_wr_en,
  input  logic [PW-1:0] pos_wr_data,
  input  logic          op_valid,
  input  logic          op_use_var_pos,
  input  logic          op_use_imm,
  input  logic          op_zero_fill,
  input  logic [PW-1:0] op_pos,
  input  logic [LW-1:0] op_len,
  input  logic [W-1:0]  op_src,
  input  logic [IW-1:0] op_imm,
  input  logic [W-1:0]  op_old_dst,
  output logic          res_valid,
  output logic [W-1:0]  res_data
);
  fld_mode_t    mode;
  logic [PW-1:0] stored_pos;
  logic [PW-1:0] eff_pos;
  logic [W-1:0]  field_data;
  logic [W-1:0]  fld_mask;
  logic [W-1:0]  fld_bits;
  logic [W-1:0]  merged;

  assign mode = '{use_var_pos: op_use_var_pos, use_imm: op_use_imm,
                  zero_fill: op_zero_fill};

  fld_pos_reg #(.PW(PW)) u_pos (
    .clk(clk), .rst_n(rst_n), .wr_en(pos_wr_en),
    .wr_data(pos_wr_data), .pos_q(stored_pos)
  );

  fld_operand_sel #(.W(W), .PW(PW), .IW(IW)) u_sel (
    .use_imm(mode.use_imm), .use_var_pos(mode.use_var_pos),
    .src(op_src), .imm(op_imm), .imm_pos(op_pos), .reg_pos(stored_pos),
    .field_data(field_data), .eff_pos(eff_pos)
  );

  fld_place #(.W(W), .PW(PW), .LW(LW)) u_place (
    .pos(eff_pos), .len(op_len), .data(field_data),
    .mask(fld_mask), .placed(fld_bits)
  );

  always_comb begin
    merged = fld_bits | (mode.zero_fill ? '0 : (op_old_dst & ~fld_mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res_data <= merged;
    end
  end

  // R9: one-cycle latency
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_data));
  // R2: zero mode leaves nothing outside the field
  p_zero_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_zero_fill) |=> (res_data & ~$past(fld_mask)) == '0);
  // R3: merge mode keeps old destination outside the field
  p_merge_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_zero_fill) |=>
      (res_data & ~$past(fld_mask)) == ($past(op_old_dst) & ~$past(fld_mask)));
endmodule

// File: tb/tb_fld_insert_unit.sv
module tb_fld_insert_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pos_wr_en = 1'b0;
  logic [4:0]  pos_wr_data = '0;
  logic        op_valid = 1'b0;
  logic        op_use_var_pos = 1'b0;
  logic        op_use_imm = 1'b0;
  logic        op_zero_fill = 1'b0;
  logic [4:0]  op_pos = '0;
  logic [5:0]  op_len = '0;
  logic [31:0] op_src = '0;
  logic [4:0]  op_imm = '0;
  logic [31:0] op_old_dst = '0;
  logic        res_valid;
  logic [31:0] res_data;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fld_insert_unit dut (
    .clk(clk), .rst_n(rst_n), .pos_wr_en(pos_wr_en), .pos_wr_data(pos_wr_data),
    .op_valid(op_valid), .op_use_var_pos(op_use_var_pos), .op_use_imm(op_use_imm),
    .op_zero_fill(op_zero_fill), .op_pos(op_pos), .op_len(op_len), .op_src(op_src),
    .op_imm(op_imm), .op_old_dst(op_old_dst), .res_valid(res_valid), .res_data(res_data)
  );

  // bit-by-bit model: bit i takes data[i-pos] inside the field
  function automatic logic [31:0] model(input logic [31:0] data, input logic [31:0] old,
                                        input int pos, input int len, input bit zero);
    logic [31:0] r;
    int l;
    l = (len > 32) ? 32 : len;
    for (int i = 0; i < 32; i++) begin
      if (i >= pos && (i - pos) < l) r[i] = data[i - pos];
      else r[i] = zero ? 1'b0 : old[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation; result sampled at the negedge after the capturing edge
  task automatic run_op(input string req, input bit var_pos, input bit use_imm,
                        input bit zero, input int pos, input int len,
                        input logic [31:0] src, input logic [4:0] imm,
                        input logic [31:0] old, input logic [31:0] exp);
    @(negedge clk);
    op_valid = 1'b1; op_use_var_pos = var_pos; op_use_imm = use_imm;
    op_zero_fill = zero; op_pos = pos[4:0]; op_len = len[5:0];
    op_src = src; op_imm = imm; op_old_dst = old;
    @(negedge clk);
    op_valid = 1'b0; pos_wr_en = 1'b0;
    check({req, " valid"}, {31'b0, res_valid}, 32'd1);
    check(req, res_data, exp);
  endtask

  task automatic t_reset();
    check("R10 valid", {31'b0, res_valid}, 32'd0);
    check("R10 data", res_data, 32'd0);
    // R5/R10: stored position is 0 after reset (op_pos=9 must be ignored)
    run_op("R5 reset pos", 1, 0, 1, 9, 4, 32'h0000_000B, 0, 0,
           model(32'hB, 0, 0, 4, 1));
  endtask

  task automatic t_basic();
    run_op("R1 R3 merge", 0, 0, 0, 8, 8, 32'hFFFF_FFA5, 0, 32'h1234_5678,
           model(32'hFFFF_FFA5, 32'h1234_5678, 8, 8, 0));
    run_op("R1 R2 shift", 0, 0, 1, 4, 32, 32'h8765_4321, 0, 32'hFFFF_FFFF,
           32'h8765_4321 << 4);
    run_op("R3 merge odd", 0, 0, 0, 13, 7, 32'h0000_0055, 0, 32'hDEAD_BEEF,
           model(32'h55, 32'hDEAD_BEEF, 13, 7, 0));
  endtask

  task automatic t_var_pos();
    // R5: a write in the same cycle as an op is not seen by that op
    @(negedge clk);
    pos_wr_en = 1'b1; pos_wr_data = 5'd20;
    op_valid = 1'b1; op_use_var_pos = 1; op_use_imm = 0; op_zero_fill = 1;
    op_pos = 5'd3; op_len = 6'd4; op_src = 32'hF; op_old_dst = 0;
    @(negedge clk);
    op_valid = 1'b0; pos_wr_en = 1'b0;
    check("R5 same-cycle write", res_data, 32'h0000_000F);
    run_op("R4 var pos", 1, 0, 1, 3, 4, 32'hF, 0, 0, 32'h00F0_0000);
  endtask

  task automatic t_imm();
    run_op("R6 set field", 0, 1, 0, 4, 8, 32'h1234_5678, 5'h1F, 32'h0000_0000,
           32'h0000_0FF0);
    run_op("R6 clear field", 0, 1, 0, 16, 8, 32'hFFFF_FFFF, 5'h00, 32'hFFFF_FFFF,
           32'hFF00_FFFF);
    run_op("R6 sign ext -16", 0, 1, 1, 0, 32, 0, 5'h10, 0, 32'hFFFF_FFF0);
    run_op("R6 positive 15", 0, 1, 1, 2, 8, 32'hFFFF_FFFF, 5'h0F, 0, 32'h0000_003C);
  endtask

  task automatic t_edges();
    run_op("R7 clip top", 0, 0, 0, 28, 8, 32'h0000_00A5, 0, 32'h0123_4567,
           32'h5123_4567);
    run_op("R8 len0 merge", 0, 0, 0, 5, 0, 32'hFFFF_FFFF, 0, 32'hCAFE_F00D,
           32'hCAFE_F00D);
    run_op("R8 len0 zero", 0, 0, 1, 5, 0, 32'hFFFF_FFFF, 0, 32'hCAFE_F00D, 32'h0);
    run_op("R8 len40", 0, 0, 0, 0, 40, 32'h1357_9BDF, 0, 32'hFFFF_FFFF, 32'h1357_9BDF);
    // R9: after an idle cycle no valid and data held
    @(negedge clk);
    check("R9 idle valid", {31'b0, res_valid}, 32'd0);
    check("R9 hold data", res_data, 32'h1357_9BDF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_var_pos();
    t_imm();
    t_edges();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule